// File: doc/BRIEF.md
# Serial Device Programming Master

This block reads the program memory of a target microcontroller over a two-wire serial programming link. The link has a serial clock and one bidirectional data line. Two enables control the target's programming-voltage rail and its supply rail. A start request with a word count begins the operation. The block first holds every line low so the rails can discharge. It then runs the timed power-up that puts the target into programming mode.

For each word, the block does four things in order:
- It sends a 6-bit read command.
- It turns the data pin around and clocks in a 14-bit word.
- It sends a 6-bit increment-address command.
- It clocks a second 14-bit slot, whose contents it throws away.

Every captured word appears on a parallel bus with a one-cycle strobe and the address it came from. When the last word is done, all lines and both rail enables drop low again.

A clock divider setting fixes the serial half-period. Both the divider setting and the word count are captured when start is accepted.

Top module: `serprog_master`

## Requirements
- R1: After reset, and whenever the block is idle, `sclk`, `sdat_oe`, `sdat_out`, `vpp_en`, `vdd_en`, `busy` and `word_valid` are all low.
- R2: When `start` is accepted while idle, `busy` rises on the next cycle. For 2*SETTLE_PER serial half-periods after that, all four link lines and both enables stay low.
- R3: `vpp_en` then rises alone for 2*VPP_PER half-periods. Next, `vdd_en` also rises, and both stay high for 2*VDD_PER half-periods before the first serial clock pulse. `vdd_en` is never high while `vpp_en` is low.
- R4: One serial half-period lasts `half_div`+1 clock cycles. Each bit is a high phase followed by a low phase.
- R5: A command is 6 bits, least significant bit first, driven on `sdat_out` with `sdat_oe` high. Each bit is held across its high and low phases. The read code is 6'b000100 and the increment code is 6'b000110. Commands alternate read, increment, read, and so on, two per word.
- R6: Each read slot has 14 clocks with `sdat_oe` low. Bit k (LSB first) is sampled from `sdat_in` at the end of the low phase of the k-th clock.
- R7: The word from the slot after a read command appears on `word_data` with a single-cycle `word_valid`. The slot after an increment command produces no strobe. Exactly `word_count` strobes occur per run.
- R8: `word_addr` is zero for the first word and advances by one at the end of each increment command. When `word_valid` is high, it holds the address of the word on `word_data`.
- R9: After the last slot, all lines and both enables return low and `busy` falls. With `word_count` of zero, this happens straight after the power-up, with no clock pulses sent.
- R10: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a read run when idle |
| word_count | input | CNT_W | Number of words to read, captured at start |
| half_div | input | DIV_W | Serial half-period minus one, in clock cycles, captured at start |
| sdat_in | input | 1 | Data line level as seen from the target |
| sclk | output | 1 | Serial clock |
| sdat_oe | output | 1 | Drive enable for the data line |
| sdat_out | output | 1 | Data line value when driven |
| vpp_en | output | 1 | Programming-voltage rail enable |
| vdd_en | output | 1 | Target supply enable |
| busy | output | 1 | High from accepted start until power-down |
| word_data | output | 14 | Last captured program word |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_addr | output | CNT_W | Address of the word on `word_data` |

## Verification
A behavioural target model in the bench decodes each command from the clock edges. It answers read slots with an address-dependent pattern and answers the discarded slots with the inverse of that pattern. A wrong slot choice, bit order or sampling edge therefore shows up as a data mismatch.

The runs mix several conditions:
- Directed runs cover a single word at the fastest divider setting and a zero word count.
- A long-divider run includes a second start pulse mid-run, which tells a latched count apart from a live one.
- Random runs vary the word count and the divider. Phase lengths that scale correctly with `half_div`+1 are thereby told apart from fixed-length ones.

// File: rtl/serprog_pkg.sv
// Shared types and constants for the serial programming master.
// Assumes a 6-bit command field and a 14-bit data word.
package serprog_pkg;
    localparam int CMD_W  = 6;
    localparam int DATA_W = 14;
    localparam logic [CMD_W-1:0] CODE_READ = 6'b000100;
    localparam logic [CMD_W-1:0] CODE_INC  = 6'b000110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_VPP,
        ST_VDD,
        ST_CMD,
        ST_READ
    } st_t;
endpackage

// File: rtl/serprog_tick.sv
// Half-period tick generator. Emits one tick every div+1 cycles while run
// is high. Restarts from zero whenever run is low, so the first tick of a
// run comes exactly div+1 cycles after run rises.
module serprog_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count cycles within a half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/serprog_shift.sv
// Command and read shift registers. The command register loads a code and
// presents its LSB, shifting right once per finished bit. The receive
// register shifts new bits in at the top, so an LSB-first word ends up aligned.
module serprog_shift
    import serprog_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_load,
    input  logic [CMD_W-1:0]  tx_code,
    input  logic              tx_shift,
    input  logic              rx_sample,
    input  logic              sdat_in,
    output logic              tx_bit,
    output logic [DATA_W-1:0] rx_next
);
    logic [CMD_W-1:0]  tx_sr;
    logic [DATA_W-1:0] rx_sr;

    assign tx_bit  = tx_sr[0];
    assign rx_next = {sdat_in, rx_sr[DATA_W-1:1]};

    // Load or advance the outgoing command.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_sr <= '0;
        else if (tx_load)  tx_sr <= tx_code;
        else if (tx_shift) tx_sr <= {1'b0, tx_sr[CMD_W-1:1]};
    end

    // Gather incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_sr <= '0;
        else if (rx_sample) rx_sr <= rx_next;
    end
endmodule

// File: rtl/serprog_seq.sv
// Run sequencer: settle, rail entry, then per word read command, kept slot,
// increment command, discarded slot. One phase lasts one tick. Within a bit
// state an even tick count means clock high and an odd count means clock low.
module serprog_seq
    import serprog_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int SETTLE_PER = 1024,
    parameter int VPP_PER    = 256,
    parameter int VDD_PER    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    input  logic              tick,
    input  logic [DATA_W-1:0] rx_next,
    input  logic              tx_bit,
    output logic              tx_load,
    output logic [CMD_W-1:0]  tx_code,
    output logic              tx_shift,
    output logic              rx_sample,
    output logic              sclk,
    output logic              sdat_oe,
    output logic              sdat_out,
    output logic              vpp_en,
    output logic              vdd_en,
    output logic              busy,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic [CNT_W-1:0]  word_addr
);
    localparam int M1   = (SETTLE_PER > VPP_PER) ? SETTLE_PER : VPP_PER;
    localparam int M2   = (M1 > VDD_PER) ? M1 : VDD_PER;
    localparam int LONG = (M2 > DATA_W) ? M2 : DATA_W;
    localparam int TW   = $clog2(2 * LONG) + 1;

    st_t             st;
    logic [TW-1:0]   cnt;
    logic [TW-1:0]   last;
    logic            inc_ph;
    logic [CNT_W-1:0] left;
    logic            end_st;
    logic            bit_end;
    logic            in_bits;

    // Final tick index of the current state.
    always_comb begin
        case (st)
            ST_SETTLE: last = TW'(2 * SETTLE_PER - 1);
            ST_VPP:    last = TW'(2 * VPP_PER - 1);
            ST_VDD:    last = TW'(2 * VDD_PER - 1);
            ST_CMD:    last = TW'(2 * CMD_W - 1);
            ST_READ:   last = TW'(2 * DATA_W - 1);
            default:   last = '0;
        endcase
    end

    assign end_st  = tick && (cnt == last);
    assign bit_end = tick && cnt[0];
    assign in_bits = (st == ST_CMD) || (st == ST_READ);

    assign tx_load = end_st && (((st == ST_VDD) && (left != '0)) ||
                                ((st == ST_READ) && !(inc_ph && (left == CNT_W'(1)))));
    assign tx_code   = ((st == ST_READ) && !inc_ph) ? CODE_INC : CODE_READ;
    assign tx_shift  = bit_end && (st == ST_CMD);
    assign rx_sample = bit_end && (st == ST_READ);

    assign sclk     = in_bits && !cnt[0];
    assign sdat_oe  = (st == ST_CMD);
    assign sdat_out = (st == ST_CMD) && tx_bit;
    assign vdd_en   = (st == ST_VDD) || in_bits;
    assign vpp_en   = (st == ST_VPP) || vdd_en;
    assign busy     = (st != ST_IDLE);

    // State, tick count, word bookkeeping and capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cnt        <= '0;
            inc_ph     <= 1'b0;
            left       <= '0;
            word_addr  <= '0;
            word_data  <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (st == ST_IDLE) begin
                cnt    <= '0;
                inc_ph <= 1'b0;
                if (start) begin
                    st        <= ST_SETTLE;
                    left      <= word_count;
                    word_addr <= '0;
                end
            end else if (end_st) begin
                cnt <= '0;
                case (st)
                    ST_SETTLE: st <= ST_VPP;
                    ST_VPP:    st <= ST_VDD;
                    ST_VDD:    st <= (left == '0) ? ST_IDLE : ST_CMD;
                    ST_CMD: begin
                        st <= ST_READ;
                        if (inc_ph) word_addr <= word_addr + 1'b1;
                    end
                    default: begin
                        if (!inc_ph) begin
                            word_valid <= 1'b1;
                            word_data  <= rx_next;
                            inc_ph     <= 1'b1;
                            st         <= ST_CMD;
                        end else begin
                            inc_ph <= 1'b0;
                            left   <= left - 1'b1;
                            st     <= (left == CNT_W'(1)) ? ST_IDLE : ST_CMD;
                        end
                    end
                endcase
            end else if (tick) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serprog_master.sv
// Top of the serial programming master. Latches the divider setting at an
// accepted start and ties together the tick generator, the sequencer and
// the shift registers. Assumes sdat_in is already synchronous to clk.
module serprog_master
    import serprog_pkg::*;
#(
    parameter int DIV_W      = 8,
    parameter int CNT_W      = 12,
    parameter int SETTLE_PER = 1024,
    parameter int VPP_PER    = 256,
    parameter int VDD_PER    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  word_count,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              sdat_in,
    output logic              sclk,
    output logic              sdat_oe,
    output logic              sdat_out,
    output logic              vpp_en,
    output logic              vdd_en,
    output logic              busy,
    output logic [DATA_W-1:0] word_data,
    output logic              word_valid,
    output logic [CNT_W-1:0]  word_addr
);
    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic              tx_load;
    logic [CMD_W-1:0]  tx_code;
    logic              tx_shift;
    logic              rx_sample;
    logic              tx_bit;
    logic [DATA_W-1:0] rx_next;

    // Hold the divider setting for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_q <= '0;
        else if (start && !busy) div_q <= half_div;
    end

    serprog_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div_q),
        .tick  (tick)
    );

    serprog_seq #(
        .CNT_W      (CNT_W),
        .SETTLE_PER (SETTLE_PER),
        .VPP_PER    (VPP_PER),
        .VDD_PER    (VDD_PER)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_count (word_count),
        .tick       (tick),
        .rx_next    (rx_next),
        .tx_bit     (tx_bit),
        .tx_load    (tx_load),
        .tx_code    (tx_code),
        .tx_shift   (tx_shift),
        .rx_sample  (rx_sample),
        .sclk       (sclk),
        .sdat_oe    (sdat_oe),
        .sdat_out   (sdat_out),
        .vpp_en     (vpp_en),
        .vdd_en     (vdd_en),
        .busy       (busy),
        .word_data  (word_data),
        .word_valid (word_valid),
        .word_addr  (word_addr)
    );

    serprog_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_load   (tx_load),
        .tx_code   (tx_code),
        .tx_shift  (tx_shift),
        .rx_sample (rx_sample),
        .sdat_in   (sdat_in),
        .tx_bit    (tx_bit),
        .rx_next   (rx_next)
    );
endmodule

// File: rtl/serprog_checker.sv
// Protocol checker for the serial programming master, bound to its top.
module serprog_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic sclk,
    input logic sdat_oe,
    input logic sdat_out,
    input logic vpp_en,
    input logic vdd_en,
    input logic word_valid
);
    AST_RAIL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_en |-> vpp_en); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(sclk || sdat_oe || vpp_en || vdd_en || word_valid)); // R1

    AST_CLK_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (vdd_en && vpp_en)); // R3

    AST_OUT_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_out |-> sdat_oe); // R5

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R7

    AST_VALID_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> busy); // R7

    AST_POWER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !vpp_en && !vdd_en); // R9
endmodule

bind serprog_master serprog_checker u_chk (.*);

// File: tb/sim_serprog_master.sv
// Bench: behavioural target model, directed and random runs.
module sim_serprog_master;
    localparam int SET_P = 16;
    localparam int VPP_P = 256;
    localparam int VDD_P = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] word_count = '0;
    logic [7:0]  half_div = '0;
    logic        sdat_in = 1'b0;
    logic        sclk, sdat_oe, sdat_out, vpp_en, vdd_en, busy, word_valid;
    logic [13:0] word_data;
    logic [11:0] word_addr;

    always #4 clk = ~clk;

    serprog_master #(.SETTLE_PER(SET_P), .VPP_PER(VPP_P), .VDD_PER(VDD_P)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
        .half_div(half_div), .sdat_in(sdat_in), .sclk(sclk), .sdat_oe(sdat_oe),
        .sdat_out(sdat_out), .vpp_en(vpp_en), .vdd_en(vdd_en), .busy(busy),
        .word_data(word_data), .word_valid(word_valid), .word_addr(word_addr)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    int salt = 0;
    int exp_div = 0;
    // monitor state
    int c_settle, c_vpp, c_vdd, c_hi, hi_bad, settle_bad;
    int n_cmd, n_rdbits, v_cnt, cmd_n, rd_idx, taddr;
    bit seen_clk, slot_keep, prev_sclk;
    logic [5:0] cmd_sr;

    function automatic logic [13:0] mem(int a);
        return 14'((a * 745) ^ salt ^ (a << 5));
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clr_mon();
        c_settle = 0; c_vpp = 0; c_vdd = 0; c_hi = 0; hi_bad = 0; settle_bad = 0;
        n_cmd = 0; n_rdbits = 0; v_cnt = 0; cmd_n = 0; rd_idx = 0; taddr = 0;
        seen_clk = 0; slot_keep = 0; prev_sclk = 0; cmd_sr = '0;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            check(1'b0, "watchdog", cyc, 190000);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    // Target model and timing monitor, sampled between edges.
    always @(negedge clk) begin
        if (rst_n && busy) begin
            if (!vpp_en) begin
                c_settle++;
                if (sclk || sdat_oe || vdd_en) settle_bad++;
            end
            if (vpp_en && !vdd_en) c_vpp++;
            if (vdd_en && !seen_clk && !sclk) c_vdd++;
            if (sclk && !prev_sclk) begin
                seen_clk = 1;
                c_hi = 1;
                if (sdat_oe) begin
                    cmd_sr = {sdat_out, cmd_sr[5:1]};
                    cmd_n++;
                    if (cmd_n == 6) begin
                        // R5: read on even commands, increment on odd
                        check(cmd_sr == ((n_cmd % 2 == 0) ? 6'b000100 : 6'b000110),
                              "R5 command code", cmd_sr, (n_cmd % 2 == 0) ? 4 : 6);
                        slot_keep = (cmd_sr == 6'b000100);
                        if (cmd_sr == 6'b000110) taddr++;
                        n_cmd++;
                        cmd_n = 0;
                        rd_idx = 0;
                    end
                end else begin
                    sdat_in = slot_keep ? mem(taddr)[rd_idx % 14] : ~mem(taddr)[rd_idx % 14];
                    rd_idx++;
                    n_rdbits++;
                end
            end else if (sclk) begin
                c_hi++;
            end else if (prev_sclk) begin
                if (c_hi != exp_div + 1) hi_bad++;
            end
            prev_sclk = sclk;
        end
        if (rst_n && word_valid) begin
            check(word_data == mem(v_cnt), "R6 captured word", word_data, mem(v_cnt));
            check(word_addr == 12'(v_cnt), "R8 word address", word_addr, v_cnt);
            v_cnt++;
        end
    end

    task automatic run_case(int n, int d, bit poke);
        word_count = 12'(n);
        half_div = 8'(d);
        exp_div = d;
        clr_mon();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            word_count = 12'(n + 3);
            half_div = 8'(d + 2);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (busy) @(negedge clk);
        check(c_settle == 2 * SET_P * (d + 1), "R2 settle length", c_settle, 2 * SET_P * (d + 1));
        check(settle_bad == 0, "R2 lines low in settle", settle_bad, 0);
        check(c_vpp == 2 * VPP_P * (d + 1), "R3 vpp-only length", c_vpp, 2 * VPP_P * (d + 1));
        check(c_vdd == 2 * VDD_P * (d + 1), "R3 vdd before clock", c_vdd, 2 * VDD_P * (d + 1));
        check(hi_bad == 0, "R4 clock high phase", hi_bad, 0);
        check(n_cmd == 2 * n, "R5 command count", n_cmd, 2 * n);
        check(n_rdbits == 28 * n, "R6 read clocks", n_rdbits, 28 * n);
        check(v_cnt == n, poke ? "R10 strobes with start ignored" : "R7 strobe count", v_cnt, n);
        check({sclk, sdat_oe, sdat_out, vpp_en, vdd_en} == 5'b0, "R9 lines low after run",
              {sclk, sdat_oe, sdat_out, vpp_en, vdd_en}, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5eed));
        salt = int'($urandom % 16384);
        repeat (3) @(negedge clk);
        check({sclk, sdat_oe, sdat_out, vpp_en, vdd_en, busy, word_valid} == 7'b0,
              "R1 reset state", {sclk, sdat_oe, sdat_out, vpp_en, vdd_en, busy, word_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({sclk, vpp_en, vdd_en, busy} == 4'b0, "R1 idle after reset",
              {sclk, vpp_en, vdd_en, busy}, 0);
        run_case(1, 0, 1'b0);
        run_case(0, 1, 1'b0);   // R9 zero words
        run_case(3, 3, 1'b1);   // R10 start while busy
        for (int i = 0; i < 5; i++) begin
            salt = int'($urandom % 16384);
            run_case(1 + int'($urandom % 6), int'($urandom % 4), 1'b0);
        end
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule